// File: doc/BRIEF.md
# USB Suspend and Wakeup Sequencer

This block decides when a full-speed USB peripheral should fall asleep and when it should wake. It watches the decoded bus line state. Once the line has stayed idle for longer than a set number of milliseconds, it raises a suspend interrupt. Software may then confirm entry by writing its go-suspend control bit to 1 and back to 0. The block then asserts the suspend pin at once and, a fixed delay later, gates the internal clocks off.

While asleep, the block resumes on either of two kinds of event:

- A K state held on the bus long enough. The block goes straight back to the awake state.
- A HIGH wake pin or a LOW chip select. The block first drives a K state onto the bus for a fixed time as a remote wakeup, then returns to the awake state.

All durations are counted in pulses of an external 1 ms tick. A bus-status bit follows whether the line is idle, so software can abandon a suspend entry that the host has already interrupted.

Top module: `suspend_wake_seq`

## Requirements
- R1: After reset, suspendOut, kDrive and suspIrq are 0 and clkEnable equals clkRunBit.
- R2: Line encoding is 2'b00 idle, 2'b01 K, 2'b10 and 2'b11 other. suspIrq becomes 1 once IDLE_MS+1 msTick pulses (default 4) arrive while the line stays idle; after only IDLE_MS pulses it is still 0. Any non-idle state restarts the count.
- R3: busStat is 1 while the line is idle and 0 one cycle after it leaves idle. Leaving idle while awake clears suspIrq and discards a partly completed go-suspend handshake.
- R4: Suspend is entered only when goSuspBit goes 1 and then 0 while suspIrq is 1. A handshake made with no pending interrupt has no effect on suspendOut.
- R5: On suspend entry, suspendOut goes to 1 with clocks still enabled. clkEnable drops to 0 after SUSP_DELAY_MS ticks (default 2).
- R6: clkEnable is 0 whenever clkRunBit is 0.
- R7: During suspend, a K state held for RESUME_K_MS ticks (default 20) resumes the device: suspendOut goes to 0, clkEnable follows clkRunBit again, and kDrive stays 0. A K run broken before it completes does not resume.
- R8: During suspend, wakePin HIGH or csN LOW resumes the device. The block drops suspendOut and holds kDrive at 1 for WAKE_MS ticks (default 10); the two pins are synchronised with two flops.
- R9: Resuming clears suspIrq. Idle detection restarts from zero only once the awake state is reached, so a further IDLE_MS+1 idle ticks are needed.
- R10: During suspend, the "other" line states and a partial K run neither resume the device nor change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineState | input | 2 | Decoded bus state: 00 idle, 01 K, 1x other |
| wakePin | input | 1 | Asynchronous wake request, active HIGH |
| csN | input | 1 | Asynchronous chip select, active LOW |
| clkRunBit | input | 1 | Software clock-run control |
| goSuspBit | input | 1 | Software go-suspend control |
| msTick | input | 1 | One-cycle pulse every millisecond |
| suspendOut | output | 1 | Suspend pin, HIGH while suspending or suspended |
| clkEnable | output | 1 | Internal clock gate enable |
| kDrive | output | 1 | Request to drive K state for remote wakeup |
| suspIrq | output | 1 | Suspend interrupt bit |
| busStat | output | 1 | 1 while the bus line is idle |

## Verification
The bench aims at the off-by-one edges of every tick window:

- The third versus the fourth idle tick. A design that fires on the third raises the interrupt early.
- The second entry-delay tick, where clocks must stop.
- The nineteenth versus the twentieth K tick.
- The ninth versus the tenth remote-wakeup tick.

It also breaks a K run with an "other" state and checks that a design summing broken runs would wake in error. It aborts a handshake by leaving idle and checks that a design keeping stale arming state would still enter suspend. It sends a handshake with no interrupt pending. After a remote wakeup it counts idle ticks afresh, which exposes a design that counted idle during the wakeup drive. Randomised idle-run lengths cross-check the interrupt against a model function.

// File: rtl/susp_pkg.sv
package susp_pkg;
  localparam logic [1:0] LINE_IDLE = 2'b00;
  localparam logic [1:0] LINE_K    = 2'b01;

  typedef enum logic [1:0] {ST_AWAKE, ST_ENTER, ST_SLEEP, ST_WAKE} seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic idleClr;
    logic seqClr;
    logic seqRun;
    logic kRun;
  } seqStrobe_t;

  // Flags from datapath to control
  typedef struct packed {
    logic idleExpired;
    logic kHeld;
    logic delayDone;
    logic wakeDone;
    logic wakeReq;
    logic lineIdle;
  } seqFlags_t;
endpackage

// File: rtl/susp_datapath.sv
module susp_datapath
  import susp_pkg::*;
#(
  parameter int IDLE_MS       = 3,
  parameter int SUSP_DELAY_MS = 2,
  parameter int RESUME_K_MS   = 20,
  parameter int WAKE_MS       = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lineState,
  input  logic       wakePin,
  input  logic       csN,
  input  logic       msTick,
  input  seqStrobe_t strobe,
  output seqFlags_t  flags,
  output logic       busStat
);
  localparam int IDLE_LIM = IDLE_MS + 1;
  localparam int SEQ_LIM  = (SUSP_DELAY_MS > WAKE_MS) ? SUSP_DELAY_MS : WAKE_MS;
  localparam int IW = $clog2(IDLE_LIM + 1);
  localparam int KW = $clog2(RESUME_K_MS + 1);
  localparam int SW = $clog2(SEQ_LIM + 1);
  localparam int SYNC_STAGES = 2;

  logic [IW-1:0] idleCnt;
  logic [KW-1:0] kCnt;
  logic [SW-1:0] seqCnt;
  logic [SYNC_STAGES-1:0] wakeSync;
  logic [SYNC_STAGES-1:0] csSync;
  logic lineIdle, lineK;

  assign lineIdle = (lineState == LINE_IDLE);
  assign lineK    = (lineState == LINE_K);

  // Idle run length in ticks, saturating
  always_ff @(posedge clk) begin
    if (!rstN || strobe.idleClr || !lineIdle) idleCnt <= '0;
    else if (msTick && idleCnt != IW'(IDLE_LIM)) idleCnt <= idleCnt + 1'b1;
  end

  // Unbroken K run length in ticks
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.kRun || !lineK) kCnt <= '0;
    else if (msTick && kCnt != KW'(RESUME_K_MS)) kCnt <= kCnt + 1'b1;
  end

  // Shared sequence timer for entry delay and wakeup drive
  always_ff @(posedge clk) begin
    if (!rstN || strobe.seqClr) seqCnt <= '0;
    else if (strobe.seqRun && msTick && seqCnt != SW'(SEQ_LIM)) seqCnt <= seqCnt + 1'b1;
  end

  // Pin synchronisers
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) begin
            wakeSync[0] <= 1'b0;
            csSync[0]   <= 1'b1;
          end else begin
            wakeSync[0] <= wakePin;
            csSync[0]   <= csN;
          end
        end
      end else begin : gRest
        always_ff @(posedge clk) begin
          if (!rstN) begin
            wakeSync[s] <= 1'b0;
            csSync[s]   <= 1'b1;
          end else begin
            wakeSync[s] <= wakeSync[s-1];
            csSync[s]   <= csSync[s-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) busStat <= 1'b0;
    else       busStat <= lineIdle;
  end

  always_comb begin
    flags.idleExpired = (idleCnt >= IW'(IDLE_LIM));
    flags.kHeld       = (kCnt >= KW'(RESUME_K_MS));
    flags.delayDone   = (seqCnt >= SW'(SUSP_DELAY_MS));
    flags.wakeDone    = (seqCnt >= SW'(WAKE_MS));
    flags.wakeReq     = wakeSync[SYNC_STAGES-1] | ~csSync[SYNC_STAGES-1];
    flags.lineIdle    = lineIdle;
  end
endmodule

// File: rtl/susp_control.sv
module susp_control
  import susp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       goSuspBit,
  input  logic       clkRunBit,
  input  seqFlags_t  flags,
  output seqStrobe_t strobe,
  output logic       suspendOut,
  output logic       clkEnable,
  output logic       kDrive,
  output logic       suspIrq
);
  seqState_e stateQ, stateD;
  logic irqQ, goArmedQ;
  logic resuming;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_AWAKE: if (goArmedQ && !goSuspBit && irqQ && flags.lineIdle) stateD = ST_ENTER;
      ST_ENTER: begin
        if (flags.wakeReq)        stateD = ST_WAKE;
        else if (flags.kHeld)     stateD = ST_AWAKE;
        else if (flags.delayDone) stateD = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (flags.wakeReq)    stateD = ST_WAKE;
        else if (flags.kHeld) stateD = ST_AWAKE;
      end
      ST_WAKE:  if (flags.wakeDone) stateD = ST_AWAKE;
      default:  stateD = ST_AWAKE;
    endcase
  end

  assign resuming = (stateQ != ST_AWAKE) && (stateD == ST_AWAKE);

  always_comb begin
    strobe.idleClr = (stateQ != ST_AWAKE);
    strobe.seqClr  = (stateQ == ST_AWAKE) || (stateD != stateQ);
    strobe.seqRun  = (stateQ == ST_ENTER) || (stateQ == ST_WAKE);
    strobe.kRun    = (stateQ == ST_ENTER) || (stateQ == ST_SLEEP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_AWAKE;
    else       stateQ <= stateD;
  end

  always_ff @(posedge clk) begin
    if (!rstN || resuming) irqQ <= 1'b0;
    else if (stateQ == ST_AWAKE) begin
      if (!flags.lineIdle)        irqQ <= 1'b0;
      else if (flags.idleExpired) irqQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stateQ != ST_AWAKE || !flags.lineIdle || stateD != stateQ) goArmedQ <= 1'b0;
    else if (irqQ && goSuspBit) goArmedQ <= 1'b1;
  end

  assign suspendOut = (stateQ == ST_ENTER) || (stateQ == ST_SLEEP);
  assign clkEnable  = clkRunBit && (stateQ != ST_SLEEP);
  assign kDrive     = (stateQ == ST_WAKE);
  assign suspIrq    = irqQ;
endmodule

// File: rtl/suspend_wake_seq.sv
module suspend_wake_seq
  import susp_pkg::*;
#(
  parameter int IDLE_MS       = 3,
  parameter int SUSP_DELAY_MS = 2,
  parameter int RESUME_K_MS   = 20,
  parameter int WAKE_MS       = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lineState,
  input  logic       wakePin,
  input  logic       csN,
  input  logic       clkRunBit,
  input  logic       goSuspBit,
  input  logic       msTick,
  output logic       suspendOut,
  output logic       clkEnable,
  output logic       kDrive,
  output logic       suspIrq,
  output logic       busStat
);
  seqStrobe_t strobe;
  seqFlags_t  flags;

  susp_datapath #(
    .IDLE_MS(IDLE_MS), .SUSP_DELAY_MS(SUSP_DELAY_MS),
    .RESUME_K_MS(RESUME_K_MS), .WAKE_MS(WAKE_MS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lineState(lineState), .wakePin(wakePin),
    .csN(csN), .msTick(msTick), .strobe(strobe), .flags(flags), .busStat(busStat)
  );

  susp_control u_ctl (
    .clk(clk), .rstN(rstN), .goSuspBit(goSuspBit), .clkRunBit(clkRunBit),
    .flags(flags), .strobe(strobe), .suspendOut(suspendOut),
    .clkEnable(clkEnable), .kDrive(kDrive), .suspIrq(suspIrq)
  );
endmodule

// File: rtl/susp_checks.sv
module susp_checks (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] lineState,
  input logic       clkRunBit,
  input logic       goSuspBit,
  input logic       suspendOut,
  input logic       clkEnable,
  input logic       kDrive,
  input logic       suspIrq
);
  assert_irq_from_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspIrq) |-> ($past(lineState) == 2'b00));

  assert_entry_after_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspendOut) |-> !$past(goSuspBit));

  assert_clock_stop_in_suspend_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(clkEnable) && clkRunBit) |-> suspendOut);

  assert_clock_run_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    !clkRunBit |-> !clkEnable);

  assert_kdrive_awake_R8: assert property (@(posedge clk) disable iff (!rstN)
    kDrive |-> !suspendOut);

  assert_wake_ends_awake_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(kDrive) |-> (!suspendOut && clkEnable == clkRunBit));
endmodule

bind suspend_wake_seq susp_checks u_checks (
  .clk(clk), .rstN(rstN), .lineState(lineState), .clkRunBit(clkRunBit),
  .goSuspBit(goSuspBit), .suspendOut(suspendOut), .clkEnable(clkEnable),
  .kDrive(kDrive), .suspIrq(suspIrq)
);

// File: tb/suspend_wake_seq_tb.sv
module suspend_wake_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE_MS = 3, SUSP_DELAY_MS = 2, RESUME_K_MS = 20, WAKE_MS = 10;

  logic clk = 0, rstN = 0;
  logic [1:0] lineState = 2'b00;
  logic wakePin = 0, csN = 1, clkRunBit = 1, goSuspBit = 0, msTick = 0;
  logic suspendOut, clkEnable, kDrive, suspIrq, busStat;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  suspend_wake_seq #(.IDLE_MS(IDLE_MS), .SUSP_DELAY_MS(SUSP_DELAY_MS),
    .RESUME_K_MS(RESUME_K_MS), .WAKE_MS(WAKE_MS)) u_dut (
    .clk(clk), .rstN(rstN), .lineState(lineState), .wakePin(wakePin), .csN(csN),
    .clkRunBit(clkRunBit), .goSuspBit(goSuspBit), .msTick(msTick),
    .suspendOut(suspendOut), .clkEnable(clkEnable), .kDrive(kDrive),
    .suspIrq(suspIrq), .busStat(busStat));

  function automatic logic expIrq(int idleTicks);
    return idleTicks > IDLE_MS;
  endfunction

  task automatic check(string req, logic actual, logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) msTick = 1;
      @(negedge clk) msTick = 0;
      waitCyc(3);
    end
  endtask

  task automatic goPulse();
    @(negedge clk) goSuspBit = 1;
    waitCyc(2);
    goSuspBit = 0;
    waitCyc(3);
  endtask

  task automatic enterSleep();
    lineState = 2'b00; waitCyc(2);
    tick(IDLE_MS + 1);
    goPulse();
    tick(SUSP_DELAY_MS);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    waitCyc(3);
    // R1 reset state
    check("R1 suspendOut", suspendOut, 0);
    check("R1 kDrive", kDrive, 0);
    check("R1 suspIrq", suspIrq, 0);
    check("R1 clkEnable", clkEnable, 1);
    rstN = 1; waitCyc(2);

    // R2 third versus fourth idle tick
    tick(IDLE_MS);
    check("R2 irq after IDLE_MS ticks", suspIrq, 0);
    tick(1);
    check("R2 irq after IDLE_MS+1 ticks", suspIrq, 1);
    check("R3 busStat idle", busStat, 1);

    // R3 leaving idle clears irq and discards handshake
    @(negedge clk) goSuspBit = 1; waitCyc(2);
    lineState = 2'b10; waitCyc(2);
    check("R3 busStat after leaving idle", busStat, 0);
    check("R3 irq cleared on activity", suspIrq, 0);
    lineState = 2'b00; goSuspBit = 0; waitCyc(3);
    check("R3 aborted handshake no entry", suspendOut, 0);

    // R2 non-idle restarts count
    tick(2); lineState = 2'b01; waitCyc(2); lineState = 2'b00; waitCyc(2);
    tick(IDLE_MS);
    check("R2 count restarted", suspIrq, 0);
    lineState = 2'b11; waitCyc(2); lineState = 2'b00; waitCyc(2);

    // R4 handshake without pending interrupt is ignored
    goPulse();
    check("R4 handshake ignored without irq", suspendOut, 0);

    // R4/R5 proper entry
    tick(IDLE_MS + 1);
    check("R4 irq before handshake", suspIrq, 1);
    @(negedge clk) goSuspBit = 1; waitCyc(4);
    check("R4 no entry while bit held", suspendOut, 0);
    goSuspBit = 0; waitCyc(3);
    check("R4 entry after release", suspendOut, 1);
    check("R5 clocks run at entry", clkEnable, 1);
    tick(SUSP_DELAY_MS - 1);
    check("R5 clocks before delay", clkEnable, 1);
    tick(1);
    check("R5 clocks stopped after delay", clkEnable, 0);
    check("R5 suspend held", suspendOut, 1);

    // R10 other states and broken K run
    lineState = 2'b10; tick(3);
    lineState = 2'b01; tick(RESUME_K_MS - 5);
    lineState = 2'b11; tick(1);
    lineState = 2'b01; tick(RESUME_K_MS - 1);
    check("R10 broken K run keeps suspend", suspendOut, 1);
    check("R10 no kDrive", kDrive, 0);
    check("R7 not yet at RESUME_K_MS-1", clkEnable, 0);
    // R7 full K run resumes
    tick(1);
    check("R7 K resume suspendOut", suspendOut, 0);
    check("R7 K resume clkEnable", clkEnable, 1);
    check("R7 K resume no kDrive", kDrive, 0);
    check("R9 irq cleared after resume", suspIrq, 0);

    // R8 remote wakeup from wake pin
    enterSleep();
    check("R8 in sleep", clkEnable, 0);
    @(negedge clk) wakePin = 1; waitCyc(5);
    check("R8 kDrive on wake pin", kDrive, 1);
    check("R8 suspend dropped", suspendOut, 0);
    check("R8 clocks back", clkEnable, 1);
    wakePin = 0;
    tick(WAKE_MS - 1);
    check("R8 kDrive at WAKE_MS-1", kDrive, 1);
    tick(1);
    check("R8 kDrive ends at WAKE_MS", kDrive, 0);
    // R9 idle restarts from zero after wakeup
    tick(IDLE_MS);
    check("R9 irq after IDLE_MS post-resume", suspIrq, 0);
    tick(1);
    check("R9 irq after IDLE_MS+1 post-resume", suspIrq, 1);

    // R8 remote wakeup from chip select
    goPulse(); tick(SUSP_DELAY_MS);
    check("R8 asleep before cs", suspendOut, 1);
    @(negedge clk) csN = 0; waitCyc(5);
    check("R8 kDrive on chip select", kDrive, 1);
    csN = 1;
    tick(WAKE_MS);
    check("R8 cs wake finished", kDrive, 0);
    check("R8 awake after cs", suspendOut, 0);

    // R6 clock-run gate
    @(negedge clk) clkRunBit = 0; #1;
    check("R6 clkRun low gates clock", clkEnable, 0);
    @(negedge clk) clkRunBit = 1; #1;
    check("R6 clkRun high", clkEnable, 1);

    // R2 random idle runs against model
    for (int t = 0; t < 20; t++) begin
      int n;
      n = $urandom_range(0, 6);
      lineState = 2'b10; waitCyc(2); lineState = 2'b00; waitCyc(2);
      tick(n);
      check("R2 random idle run", suspIrq, expIrq(n));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule